// File: doc/BRIEF.md
# Secondary Bus Arbiter with External Bypass

This block decides which master may drive a shared secondary parallel bus. Nine external masters share the bus with the bridge itself. Each master has an active-low request input and an active-low grant output. The bridge asks for the bus through a plain active-high internal request. When the bridge is granted and ready, the block gives the bridge's transaction logic a one-cycle start pulse.

A static mode strap chooses how the bus is arbitrated. With the strap low, the block arbitrates on its own. It picks among simultaneous requests in a rotating order. When nobody is asking, it leaves the grant with whoever used the bus last, unless a park-at-self configuration bit sends the idle bus back to the bridge. With the strap high, an outside arbiter takes over. Grant pin 0 then carries the bridge's own request out, and request pin 0 brings the outside arbiter's grant back in. Grant pins 1 and up stay inactive.

Top module: `sec_bus_arb`

## Requirements
- R1: During and after a synchronous active-high reset, every grant output is high, the start pulse is low, and the bus is owned by the bridge, which has no grant pin of its own.
- R2: In internal mode (strap low), a lone request pin held low while the bus is idle makes that master's grant output go low on the second rising edge after the request is first applied. The request is sampled at the first edge, and the ownership register updates at the second.
- R3: In internal mode, once a master owns the bus, its grant stays low after it releases its request, for as long as no other request arrives and park-at-self is 0.
- R4: In internal mode, candidates are ordered master 0 up to master 8, then the bridge (position 9), and the order wraps. Among simultaneous requests, the winner is the first requester after the current owner in that order. The current owner itself is considered last.
- R5: In internal mode, the grant outputs change only on an edge where the bus-idle input is high. While bus-idle is low, the grants hold even if requests change.
- R6: At most one grant output is low at any time, in either mode.
- R7: In internal mode, with park-at-self at 1, the bus idle and no request pending, ownership returns to the bridge, so all grant outputs go high.
- R8: In internal mode, when the bridge owns the bus and its request is held with the bus idle, the start pulse goes high two edges after the request is raised.
- R9: In external mode (strap high), grant output 0 is low exactly when the bridge's request was high at the previous edge. Grant outputs 8 through 1 are held high.
- R10: In external mode, request input 0 acts as the grant coming back from the outside arbiter. With the bridge requesting and the bus idle, the start pulse goes high one clock after that grant is sampled low.
- R11: In external mode, request inputs 8 through 1 have no effect on any grant output or on the start pulse.
- R12: The start pulse never lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_mode_i | input | 1 | Mode strap: 0 = internal arbitration, 1 = outside arbiter |
| park_self_i | input | 1 | Configuration bit: park the idle bus at the bridge |
| bus_idle_i | input | 1 | High while no transaction is in progress on the bus |
| req_n_i | input | N_MST | Active-low master requests; pin 0 is the returned grant in external mode |
| br_req_i | input | 1 | Bridge's own request, active high |
| gnt_n_o | output | N_MST | Active-low master grants; pin 0 is the bridge's request in external mode |
| br_start_o | output | 1 | One-cycle pulse telling the bridge to begin its transaction |

## Verification
Four properties are checked on every cycle: that at most one grant is low, that grants are frozen while the bus is busy in internal mode, the external-mode pin mapping, and that the start pulse is one cycle wide. The round-robin order, parking at the last owner, the return to the bridge under park-at-self, and the exact latencies from request to grant and from grant to start depend on a history of inputs. Only the bench's directed scenarios show those, by comparing the outputs with values worked out from the requirements.

// File: rtl/sec_bus_arb_pkg.sv
package sec_bus_arb_pkg;
  typedef enum logic {
    MODE_INTERNAL = 1'b0,
    MODE_EXTERNAL = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/arb_req_sample.sv
// Registers active-low request pins into active-high request bits.
module arb_req_sample #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] req_n_i,
  output logic [W-1:0] req_q_o
);
  always_ff @(posedge clk) begin
    if (rst) req_q_o <= '0;
    else     req_q_o <= ~req_n_i;
  end
endmodule

// File: rtl/arb_rr_pick.sv
// Rotating-priority picker: first requester after the current owner, owner last.
module arb_rr_pick #(
  parameter int NC = 10,
  localparam int IW = $clog2(NC)
) (
  input  logic [NC-1:0] req_i,
  input  logic [IW-1:0] cur_i,
  output logic          any_o,
  output logic [IW-1:0] win_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    win_o = cur_i;
    any_o = |req_i;
    for (int off = 1; off <= NC; off++) begin
      int idx;
      idx = (int'(cur_i) + off) % NC;
      if (!found && req_i[idx]) begin
        win_o = IW'(idx);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sec_bus_arb.sv
module sec_bus_arb
  import sec_bus_arb_pkg::*;
#(
  parameter int N_MST = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_mode_i,
  input  logic             park_self_i,
  input  logic             bus_idle_i,
  input  logic [N_MST-1:0] req_n_i,
  input  logic             br_req_i,
  output logic [N_MST-1:0] gnt_n_o,
  output logic             br_start_o
);
  localparam int NC = N_MST + 1;          // masters plus the bridge
  localparam int IW = $clog2(NC);
  localparam logic [IW-1:0] BR_IDX = IW'(N_MST);

  arb_mode_e        mode;
  logic [N_MST-1:0] req_q;
  logic             br_req_q;
  logic [IW-1:0]    owner_q;
  logic [NC-1:0]    cand;
  logic             any_req;
  logic [IW-1:0]    winner;
  logic             grant_seen;

  assign mode = arb_mode_e'(ext_mode_i);

  arb_req_sample #(.W(N_MST)) u_sample (
    .clk     (clk),
    .rst     (rst),
    .req_n_i (req_n_i),
    .req_q_o (req_q)
  );

  always_ff @(posedge clk) begin
    if (rst) br_req_q <= 1'b0;
    else     br_req_q <= br_req_i;
  end

  assign cand = {br_req_q, req_q};

  arb_rr_pick #(.NC(NC)) u_pick (
    .req_i (cand),
    .cur_i (owner_q),
    .any_o (any_req),
    .win_o (winner)
  );

  // Ownership: moves only on idle edges in internal mode.
  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= BR_IDX;
    end else if (mode == MODE_INTERNAL && bus_idle_i) begin
      if (any_req)          owner_q <= winner;
      else if (park_self_i) owner_q <= BR_IDX;
    end
  end

  // Grant pin decode; pin 0 doubles as the outgoing request in external mode.
  for (genvar g = 0; g < N_MST; g++) begin : g_gnt
    if (g == 0) begin : g_pin0
      assign gnt_n_o[g] = (mode == MODE_EXTERNAL) ? ~br_req_q
                                                  : ~(owner_q == IW'(g));
    end else begin : g_pinx
      assign gnt_n_o[g] = (mode == MODE_EXTERNAL) ? 1'b1
                                                  : ~(owner_q == IW'(g));
    end
  end

  assign grant_seen = (mode == MODE_EXTERNAL) ? req_q[0] : (owner_q == BR_IDX);

  always_ff @(posedge clk) begin
    if (rst) br_start_o <= 1'b0;
    else     br_start_o <= grant_seen && br_req_q && bus_idle_i && !br_start_o;
  end
endmodule

// File: rtl/sec_bus_arb_chk.sv
module sec_bus_arb_chk #(
  parameter int N_MST = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             ext_mode_i,
  input logic             bus_idle_i,
  input logic             br_req_i,
  input logic [N_MST-1:0] gnt_n_o,
  input logic             br_start_o
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $countones(~gnt_n_o) <= 1); // R6

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst || ext_mode_i)
    !bus_idle_i |=> $stable(gnt_n_o)); // R5

  AST_EXT_UPPER_HIGH: assert property (@(posedge clk) disable iff (rst)
    ext_mode_i |-> (&gnt_n_o[N_MST-1:1])); // R9

  AST_EXT_REQ_OUT: assert property (@(posedge clk) disable iff (rst || !ext_mode_i)
    br_req_i |=> !gnt_n_o[0]); // R9

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    br_start_o |=> !br_start_o); // R12
endmodule

bind sec_bus_arb sec_bus_arb_chk #(.N_MST(N_MST)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ext_mode_i (ext_mode_i),
  .bus_idle_i (bus_idle_i),
  .br_req_i   (br_req_i),
  .gnt_n_o    (gnt_n_o),
  .br_start_o (br_start_o)
);

// File: tb/sec_bus_arb_tb_top.sv
module sec_bus_arb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 9;
  localparam logic [N-1:0] ALL_HI = '1;

  logic clk = 1'b0;
  logic rst, ext_mode, park_self, bus_idle, br_req;
  logic [N-1:0] req_n, gnt_n;
  logic start;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_bus_arb #(.N_MST(N)) dut_i (
    .clk(clk), .rst(rst), .ext_mode_i(ext_mode), .park_self_i(park_self),
    .bus_idle_i(bus_idle), .req_n_i(req_n), .br_req_i(br_req),
    .gnt_n_o(gnt_n), .br_start_o(start)
  );

  function automatic logic [N-1:0] gnt_of(int m);
    return ~(N'(1) << m);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset(input logic mode);
    @(negedge clk);
    rst = 1; ext_mode = mode; park_self = 0; bus_idle = 1; br_req = 0; req_n = '1;
    edges(2);
    rst = 0;
    edges(1);
    chk("R1 grants", 32'(gnt_n), 32'(ALL_HI));
    chk("R1 start", 32'(start), 0);
  endtask

  task automatic t_single_grant();
    req_n[3] = 0;
    edges(1);
    chk("R2 not yet", 32'(gnt_n), 32'(ALL_HI));
    edges(1);
    chk("R2 granted", 32'(gnt_n), 32'(gnt_of(3)));
  endtask

  task automatic t_park_last();
    req_n[3] = 1;
    edges(3);
    chk("R3 parked at last", 32'(gnt_n), 32'(gnt_of(3)));
  endtask

  task automatic t_round_robin_and_hold();
    req_n[1] = 0; req_n[5] = 0;
    edges(2);
    chk("R4 after owner 3", 32'(gnt_n), 32'(gnt_of(5)));
    edges(1);
    chk("R4 wrap to 1", 32'(gnt_n), 32'(gnt_of(1)));
    bus_idle = 0;
    req_n[1] = 1; req_n[5] = 1; req_n[7] = 0;
    edges(3);
    chk("R5 frozen while busy", 32'(gnt_n), 32'(gnt_of(1)));
    bus_idle = 1;
    edges(1);
    chk("R5 moves when idle", 32'(gnt_n), 32'(gnt_of(7)));
  endtask

  task automatic t_park_self();
    req_n[7] = 1; park_self = 1;
    edges(3);
    chk("R7 back to bridge", 32'(gnt_n), 32'(ALL_HI));
    park_self = 0;
  endtask

  task automatic t_int_start();
    br_req = 1;
    edges(1);
    chk("R8 no start yet", 32'(start), 0);
    edges(1);
    chk("R8 start", 32'(start), 1);
    chk("R8 bridge keeps bus", 32'(gnt_n), 32'(ALL_HI));
    edges(1);
    chk("R12 pulse ends", 32'(start), 0);
    br_req = 0;
    edges(2);
  endtask

  task automatic t_ext_mode();
    t_reset(1'b1);
    br_req = 1;
    edges(1);
    chk("R9 request out on pin 0", 32'(gnt_n), 32'(gnt_of(0)));
    req_n[N-1:1] = '0;
    edges(3);
    chk("R11 upper requests ignored", 32'(gnt_n), 32'(gnt_of(0)));
    chk("R11 no start", 32'(start), 0);
    req_n[0] = 0;
    edges(1);
    chk("R10 start one later", 32'(start), 0);
    edges(1);
    chk("R10 start", 32'(start), 1);
    edges(1);
    chk("R12 ext pulse ends", 32'(start), 0);
    br_req = 0; req_n = '1;
    edges(1);
    chk("R9 request dropped", 32'(gnt_n), 32'(ALL_HI));
  endtask

  initial begin
    fork
      begin
        t_reset(1'b0);
        t_single_grant();
        t_park_last();
        t_round_robin_and_hold();
        t_park_self();
        t_int_start();
        t_ext_mode();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule